// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block drives an external successive-approximation converter through a simple start/done/error handshake. Software requests a single conversion with a one-cycle pulse, or holds a level for repeated conversions. Repeated conversions run back to back, or on ticks from an outside pacing source when pacing is switched on. Each finished conversion updates a held 12-bit result, an error flag for that conversion and a sticky error flag. A one-cycle strobe marks each new result.

A five-bit mask selects the channels that take part in round-robin operation. When the mask has any bit set, the block's own channel select moves on by itself after every conversion. It goes to the next enabled channel in ascending order and wraps to channel 0, so software only sets the starting channel. When the mask is clear, the channel stays wherever software last wrote it.

Top module: `conv_sequencer`

## Requirements
- R1: With every bit of `rr_mask_i` at 0, a completed conversion leaves `chan_o` unchanged.
- R2: With a non-zero mask, the first conversion after software writes the channel uses the written channel.
- R3: With a non-zero mask, `chan_o` becomes the next channel after each conversion. This is the next set mask bit above the current channel, wrapping from 4 to 0. A current channel of 4 or higher makes the search start at 0. A current channel that is the only enabled one is selected again.
- R4: A pulse on `start_once_i` while the block is ready raises `conv_start_o` in the same cycle and causes exactly one conversion. A pulse that arrives while a conversion is in flight is dropped.
- R5: `start_once_i` has no effect while `start_cont_i` is high.
- R6: With `start_cont_i` high and `pace_en_i` low, `conv_start_o` rises in the cycle right after the cycle in which `conv_done_i` was high.
- R7: With `start_cont_i` and `pace_en_i` both high, a conversion starts only in a cycle in which `pace_tick_i` is high while the block is ready.
- R8: `ready_o` is 1 exactly when `enable_i` is high and no conversion is in flight. It falls in the cycle after `conv_start_o` and rises in the cycle after `conv_done_i`.
- R9: While `enable_i` is low, `ready_o` is 0, `conv_start_o` stays 0 and any start request is dropped.
- R10: In the cycle after `conv_done_i`, `result_o` holds `conv_data_i` and `last_err_o` holds `conv_err_i`, both as sampled with that done. `result_valid_o` is high for exactly that one cycle.
- R11: `sticky_err_o` sets after any conversion that ends with an error, stays set through later clean conversions, and clears one cycle after `err_clr_i` is high. A new error in the same cycle as the clear keeps it set.
- R12: A write on `chan_wr_i` loads `chan_wdata_i` into `chan_o` on the next cycle, and takes priority over a round-robin step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Converter power/enable; gates all starts |
| start_once_i | input | 1 | Single conversion request pulse |
| start_cont_i | input | 1 | Repeated conversion level |
| pace_en_i | input | 1 | Repeated conversions wait for pacing ticks |
| pace_tick_i | input | 1 | Pacing tick from an outside divider |
| rr_mask_i | input | 5 | One enable bit per channel for round-robin |
| chan_wr_i | input | 1 | Software write strobe for the channel select |
| chan_wdata_i | input | 3 | Channel value to write |
| err_clr_i | input | 1 | Clear request for the sticky error flag |
| conv_start_o | output | 1 | Start pulse to the converter |
| conv_done_i | input | 1 | Converter finished, data valid |
| conv_err_i | input | 1 | Converter reports an error with this result |
| conv_data_i | input | 12 | Converter result |
| chan_o | output | 3 | Current channel select to the analog mux |
| ready_o | output | 1 | Idle and able to start a conversion |
| result_o | output | 12 | Result of the latest conversion |
| last_err_o | output | 1 | Error flag of the latest conversion |
| sticky_err_o | output | 1 | Set by any error until cleared |
| result_valid_o | output | 1 | One-cycle strobe for each new result |

## Verification
`conv_start_o` is combinational and is due in the same cycle as the request. Every other result is registered once: `ready_o` falls one cycle after a start, and result, error flags, strobe and channel select all change one cycle after the done cycle. The bench drives inputs on the falling edge. Its converter model samples a few nanoseconds later, and the checks read a little after that. Each reading therefore falls in the low phase of the cycle where the requirement places the change. Start cycles are logged so that the back-to-back gap and the channel order can be compared against the converter latency and a mask model.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic cont;
      logic paced;
      logic tick;
      logic once;
   } start_req_t;

endpackage

// File: rtl/conv_rr_picker.sv
module conv_rr_picker #(
   parameter int NCH   = 5,
   parameter int SEL_W = 3
) (
   input  logic [SEL_W-1:0] cur_i,
   input  logic [NCH-1:0]   mask_i,
   output logic [SEL_W-1:0] nxt_o
);
   localparam int LAST = NCH - 1;

   always_comb begin
      int   base;
      int   idx;
      logic found;
      nxt_o = cur_i;
      found = 1'b0;
      idx   = 0;
      base  = (int'(cur_i) >= LAST) ? 0 : int'(cur_i) + 1;
      for (int k = 0; k < NCH; k++) begin
         idx = (base + k) % NCH;
         if (!found && mask_i[idx]) begin
            nxt_o = SEL_W'(idx);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/conv_launch_ctrl.sv
module conv_launch_ctrl
   import conv_seq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       enable_i,
   input  start_req_t req_i,
   input  logic       done_i,
   output logic       launch_o,
   output logic       accept_o,
   output logic       busy_o
);
   seq_state_e state_q;
   logic       want;

   assign busy_o   = (state_q == SEQ_BUSY);
   assign want     = (req_i.cont && (!req_i.paced || req_i.tick)) ||
                     (req_i.once && !req_i.cont);
   assign launch_o = enable_i && !busy_o && want;
   assign accept_o = busy_o && done_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
      end else if (launch_o) begin
         state_q <= SEQ_BUSY;
      end else if (accept_o) begin
         state_q <= SEQ_IDLE;
      end
   end
endmodule

// File: rtl/conv_result_hold.sv
module conv_result_hold #(
   parameter int DATA_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              accept_i,
   input  logic              err_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              clr_i,
   output logic [DATA_W-1:0] result_o,
   output logic              last_err_o,
   output logic              sticky_o,
   output logic              valid_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         result_o   <= '0;
         last_err_o <= 1'b0;
         valid_o    <= 1'b0;
      end else begin
         valid_o <= accept_i;
         if (accept_i) begin
            result_o   <= data_i;
            last_err_o <= err_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sticky_o <= 1'b0;
      end else if (accept_i && err_i) begin
         sticky_o <= 1'b1;
      end else if (clr_i) begin
         sticky_o <= 1'b0;
      end
   end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
   import conv_seq_pkg::*;
#(
   parameter int NCH         = 5,
   parameter int SEL_W       = 3,
   parameter int DATA_W      = 12,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              enable_i,
   input  logic              start_once_i,
   input  logic              start_cont_i,
   input  logic              pace_en_i,
   input  logic              pace_tick_i,
   input  logic [NCH-1:0]    rr_mask_i,
   input  logic              chan_wr_i,
   input  logic [SEL_W-1:0]  chan_wdata_i,
   input  logic              err_clr_i,
   output logic              conv_start_o,
   input  logic              conv_done_i,
   input  logic              conv_err_i,
   input  logic [DATA_W-1:0] conv_data_i,
   output logic [SEL_W-1:0]  chan_o,
   output logic              ready_o,
   output logic [DATA_W-1:0] result_o,
   output logic              last_err_o,
   output logic              sticky_err_o,
   output logic              result_valid_o
);
   localparam int MIN_SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

   if (SEL_W < MIN_SEL_W) begin : g_bad_sel_w
      $error("channel select too narrow for channel count");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("channel count must be positive");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("result width must be positive");
   end

   start_req_t       req;
   logic             launch;
   logic             accept;
   logic             busy;
   logic [SEL_W-1:0] chan_q;
   logic [SEL_W-1:0] chan_nxt;

   assign req.cont  = start_cont_i;
   assign req.paced = pace_en_i;
   assign req.tick  = pace_tick_i;
   assign req.once  = start_once_i;

   conv_launch_ctrl u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .enable_i (enable_i),
      .req_i    (req),
      .done_i   (conv_done_i),
      .launch_o (launch),
      .accept_o (accept),
      .busy_o   (busy)
   );

   if (ROUND_ROBIN) begin : g_rr
      conv_rr_picker #(
         .NCH   (NCH),
         .SEL_W (SEL_W)
      ) u_pick (
         .cur_i  (chan_q),
         .mask_i (rr_mask_i),
         .nxt_o  (chan_nxt)
      );
   end else begin : g_fixed
      assign chan_nxt = chan_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chan_q <= '0;
      end else if (chan_wr_i) begin
         chan_q <= chan_wdata_i;
      end else if (accept && (|rr_mask_i)) begin
         chan_q <= chan_nxt;
      end
   end

   conv_result_hold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .accept_i   (accept),
      .err_i      (conv_err_i),
      .data_i     (conv_data_i),
      .clr_i      (err_clr_i),
      .result_o   (result_o),
      .last_err_o (last_err_o),
      .sticky_o   (sticky_err_o),
      .valid_o    (result_valid_o)
   );

   assign conv_start_o = launch;
   assign chan_o       = chan_q;
   assign ready_o      = enable_i && !busy;
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
   parameter int NCH   = 5,
   parameter int SEL_W = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             enable_i,
   input logic             start_cont_i,
   input logic             pace_en_i,
   input logic             pace_tick_i,
   input logic [NCH-1:0]   rr_mask_i,
   input logic             chan_wr_i,
   input logic             conv_done_i,
   input logic             conv_err_i,
   input logic             conv_start_o,
   input logic [SEL_W-1:0] chan_o,
   input logic             ready_o,
   input logic             result_valid_o,
   input logic             sticky_err_o
);
   assert_chan_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rr_mask_i == '0 && !chan_wr_i) |=> $stable(chan_o));

   assert_b2b_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (result_valid_o && enable_i && start_cont_i && !pace_en_i) |-> conv_start_o);

   assert_paced_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_start_o && start_cont_i && pace_en_i) |-> pace_tick_i);

   assert_busy_after_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conv_start_o |=> !ready_o);

   assert_no_start_disabled_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |-> (!conv_start_o && !ready_o));

   assert_strobe_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      result_valid_o |=> !result_valid_o);

   assert_sticky_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conv_done_i && conv_err_i && enable_i && !ready_o) |=> sticky_err_o);
endmodule

bind conv_sequencer conv_sequencer_chk #(
   .NCH   (NCH),
   .SEL_W (SEL_W)
) chk_i (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .enable_i       (enable_i),
   .start_cont_i   (start_cont_i),
   .pace_en_i      (pace_en_i),
   .pace_tick_i    (pace_tick_i),
   .rr_mask_i      (rr_mask_i),
   .chan_wr_i      (chan_wr_i),
   .conv_done_i    (conv_done_i),
   .conv_err_i     (conv_err_i),
   .conv_start_o   (conv_start_o),
   .chan_o         (chan_o),
   .ready_o        (ready_o),
   .result_valid_o (result_valid_o),
   .sticky_err_o   (sticky_err_o)
);

// File: tb/conv_sequencer_tb_top.sv
module conv_sequencer_tb_top;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        once = 1'b0;
   logic        cont = 1'b0;
   logic        pace_en = 1'b0;
   logic        tick = 1'b0;
   logic [4:0]  mask = '0;
   logic        chan_wr = 1'b0;
   logic [2:0]  chan_wd = '0;
   logic        err_clr = 1'b0;
   logic        conv_start;
   logic        conv_done = 1'b0;
   logic        conv_err = 1'b0;
   logic [11:0] conv_data = '0;
   logic [2:0]  chan;
   logic        ready;
   logic [11:0] result;
   logic        last_err;
   logic        sticky;
   logic        rvalid;

   int   n_chk = 0;
   int   n_bad = 0;
   int   cyc = 0;
   int   cnt = 0;
   int   nlog = 0;
   int   seq = 0;
   logic err_plan = 1'b0;
   logic [2:0]  cur_chan = '0;
   logic [11:0] last_data = '0;
   int   log_chan [64];
   int   log_cyc  [64];

   conv_sequencer dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .enable_i       (enable),
      .start_once_i   (once),
      .start_cont_i   (cont),
      .pace_en_i      (pace_en),
      .pace_tick_i    (tick),
      .rr_mask_i      (mask),
      .chan_wr_i      (chan_wr),
      .chan_wdata_i   (chan_wd),
      .err_clr_i      (err_clr),
      .conv_start_o   (conv_start),
      .conv_done_i    (conv_done),
      .conv_err_i     (conv_err),
      .conv_data_i    (conv_data),
      .chan_o         (chan),
      .ready_o        (ready),
      .result_o       (result),
      .last_err_o     (last_err),
      .sticky_err_o   (sticky),
      .result_valid_o (rvalid)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // converter model: samples a few ns after the falling edge
   initial begin
      forever begin
         @(negedge clk);
         #4;
         conv_done = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               conv_data = 12'(int'(cur_chan) * 256 + (seq % 256));
               conv_err  = err_plan;
               last_data = conv_data;
               conv_done = 1'b1;
               seq++;
            end
         end else if (conv_start) begin
            cur_chan = chan;
            cnt = LAT;
            if (nlog < 64) begin
               log_chan[nlog] = int'(chan);
               log_cyc[nlog]  = cyc;
            end
            nlog++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic sample();
      @(negedge clk);
      #6;
   endtask

   function automatic int next_en(input int cur, input logic [4:0] m);
      int b;
      b = (cur >= 4) ? 0 : cur + 1;
      for (int k = 0; k < 5; k++) begin
         if (m[(b + k) % 5]) return (b + k) % 5;
      end
      return cur;
   endfunction

   task automatic write_chan(input logic [2:0] v);
      @(negedge clk);
      chan_wr = 1'b1;
      chan_wd = v;
      @(negedge clk);
      chan_wr = 1'b0;
   endtask

   task automatic wait_valid(input string req);
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < 30 && !seen; i++) begin
         sample();
         if (rvalid) seen = 1'b1;
      end
      chk(seen, req, 0, 1);
   endtask

   task automatic pulse_once();
      @(negedge clk);
      once = 1'b1;
      @(negedge clk);
      once = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 40; i++) begin
         sample();
         if (ready && cnt == 0 && !conv_done) break;
      end
   endtask

   task automatic t_reset();
      sample();
      chk(ready == 1'b0, "R8 reset ready", int'(ready), 0);
      chk(result == 12'd0 && rvalid == 1'b0, "R10 reset result", int'(result), 0);
      chk(sticky == 1'b0 && last_err == 1'b0, "R11 reset errors", int'(sticky), 0);
      chk(chan == 3'd0, "R12 reset channel", int'(chan), 0);
   endtask

   task automatic t_single();
      int n0;
      enable = 1'b1;
      mask = '0;
      write_chan(3'd2);
      sample();
      chk(chan == 3'd2, "R12 channel write", int'(chan), 2);
      chk(ready == 1'b1, "R8 idle ready", int'(ready), 1);
      n0 = nlog;
      @(negedge clk);
      once = 1'b1;
      #6;
      chk(conv_start == 1'b1, "R4 same-cycle start", int'(conv_start), 1);
      @(negedge clk);
      once = 1'b1; // held into the busy cycle: must be dropped
      #6;
      chk(ready == 1'b0, "R8 busy not ready", int'(ready), 0);
      @(negedge clk);
      once = 1'b0;
      wait_valid("R10 strobe seen");
      chk(result == last_data, "R10 result value", int'(result), int'(last_data));
      chk(last_err == 1'b0, "R10 last error clear", int'(last_err), 0);
      chk(chan == 3'd2, "R1 channel fixed", int'(chan), 2);
      sample();
      chk(rvalid == 1'b0, "R10 strobe one cycle", int'(rvalid), 0);
      chk(ready == 1'b1, "R8 ready after done", int'(ready), 1);
      repeat (4) sample();
      chk(nlog - n0 == 1, "R4 one conversion only", nlog - n0, 1);
   endtask

   task automatic t_round_robin();
      int n0;
      int last;
      mask = 5'b10110;
      write_chan(3'd2);
      n0 = nlog;
      @(negedge clk);
      cont = 1'b1;
      for (int i = 0; i < 60 && nlog < n0 + 4; i++) sample();
      @(negedge clk);
      cont = 1'b0;
      wait_idle();
      chk(log_chan[n0] == 2, "R2 first channel", log_chan[n0], 2);
      chk(log_chan[n0+1] == 4, "R3 step 2->4", log_chan[n0+1], 4);
      chk(log_chan[n0+2] == 1, "R3 wrap 4->1", log_chan[n0+2], 1);
      chk(log_chan[n0+3] == 2, "R3 step 1->2", log_chan[n0+3], 2);
      chk(log_cyc[n0+1] - log_cyc[n0] == LAT + 1, "R6 back-to-back gap",
          log_cyc[n0+1] - log_cyc[n0], LAT + 1);
      last = log_chan[(nlog - 1) % 64];
      chk(int'(chan) == next_en(last, mask), "R3 final channel", int'(chan),
          next_en(last, mask));
   endtask

   task automatic t_wrap();
      mask = 5'b00001;
      write_chan(3'd3);
      pulse_once();
      wait_valid("R3 wrap strobe");
      chk(chan == 3'd0, "R3 wrap to 0", int'(chan), 0);
      wait_idle();
      mask = 5'b00100;
      write_chan(3'd2);
      pulse_once();
      wait_valid("R3 single strobe");
      chk(chan == 3'd2, "R3 only enabled kept", int'(chan), 2);
      wait_idle();
      mask = 5'b10000;
      write_chan(3'd6);
      pulse_once();
      wait_valid("R3 high start strobe");
      chk(chan == 3'd4, "R3 search from 0 when above 4", int'(chan), 4);
      wait_idle();
      mask = '0;
   endtask

   task automatic t_paced();
      int n0;
      n0 = nlog;
      @(negedge clk);
      pace_en = 1'b1;
      cont = 1'b1;
      pulse_once();
      repeat (10) sample();
      chk(nlog == n0, "R5 once ignored in continuous", nlog - n0, 0);
      chk(nlog == n0, "R7 no start without tick", nlog - n0, 0);
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (10) sample();
      chk(nlog - n0 == 1, "R7 one start per tick", nlog - n0, 1);
      @(negedge clk);
      cont = 1'b0;
      pace_en = 1'b0;
      wait_idle();
   endtask

   task automatic t_disable();
      int n0;
      n0 = nlog;
      @(negedge clk);
      enable = 1'b0;
      #6;
      chk(ready == 1'b0, "R9 ready low", int'(ready), 0);
      pulse_once();
      @(negedge clk);
      cont = 1'b1;
      repeat (8) sample();
      chk(nlog == n0, "R9 no start disabled", nlog - n0, 0);
      @(negedge clk);
      cont = 1'b0;
      enable = 1'b1;
      repeat (4) sample();
      chk(nlog == n0, "R9 request dropped", nlog - n0, 0);
   endtask

   task automatic t_errors();
      err_plan = 1'b1;
      pulse_once();
      wait_valid("R11 strobe err");
      chk(last_err == 1'b1, "R10 last error set", int'(last_err), 1);
      chk(sticky == 1'b1, "R11 sticky set", int'(sticky), 1);
      wait_idle();
      err_plan = 1'b0;
      pulse_once();
      wait_valid("R11 strobe clean");
      chk(last_err == 1'b0, "R10 last error follows latest", int'(last_err), 0);
      chk(sticky == 1'b1, "R11 sticky held", int'(sticky), 1);
      wait_idle();
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      #6;
      chk(sticky == 1'b0, "R11 sticky cleared", int'(sticky), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_round_robin();
      t_wrap();
      t_paced();
      t_disable();
      t_errors();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule